// File: doc/BRIEF.md
# Registered 64-bit Integer ALU with Word Sign-Extension

This block is the integer arithmetic and logic stage of a 64-bit register machine. Each cycle it can take an operation code and two 64-bit operands. One clock edge later it presents a 64-bit result and a trap flag. It handles these groups of operations:

- 32-bit ("word") add and subtract. Only the low halves of the operands are used, and the 32-bit result is sign-extended to 64 bits.
- Full-width ("doubleword") add and subtract, which wrap around.
- Four bitwise operations.
- Signed and unsigned set-less-than.
- An equality trap, which raises a flag instead of producing a result.

Each add and subtract comes in two forms. One form is named as an overflow-checking variant, but both forms behave the same way. The block never signals overflow. A qualifier travels alongside the operands so that downstream logic knows which cycles hold a valid result.

Top module: `wide_alu`

## Requirements
- R1: Word add (codes 0, 1) and word subtract (codes 2, 3) compute on bits 31:0 of each operand. Bits 63:32 of the result are copies of result bit 31.
- R2: The odd codes 1, 3, 5 and 7 give exactly the same result as the even code just below them. They never raise the trap flag, including when the operation overflows.
- R3: Doubleword add (codes 4, 5) and subtract (codes 6, 7) use all 64 bits and wrap modulo 2^64.
- R4: The bitwise operations use all 64 bits: code 8 is AND, 9 is OR, 10 is XOR and 11 is NOR.
- R5: Code 12 returns 1 when A < B as 64-bit two's-complement values, and 0 otherwise.
- R6: Code 13 returns 1 when A < B as 64-bit unsigned values, and 0 otherwise.
- R7: Code 14 raises the trap flag exactly when A equals B in all 64 bits, and its result is always zero.
- R8: Code 15 is unused. It returns a zero result with the trap flag low.
- R9: When in_valid is sampled high on an edge, out_valid is high for the following cycle and carries that operation's result. When in_valid is low, out_valid is low in the next cycle.
- R10: While rst is high, out_valid, out_result and out_trap are cleared to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered result |
| out_trap | output | 1 | Registered equality-trap flag |

## Verification
The assertions look one cycle back at in_op and in_valid, so they rely on these inputs being known (never X or Z) on every edge outside reset. They also rely on in_valid being held low while reset is active. The stimulus meets both conditions: the bench drives every input from a task on the falling clock edge, keeps in_valid low during reset, and always sets all four input fields together. The operand values are chosen to sit on the sign boundaries at bits 31 and 63, to make both operands equal, and otherwise to be pseudo-random with a fixed seed. Every one of the sixteen codes is exercised.

// File: rtl/wide_alu_pkg.sv
package wide_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADDW   = 4'd0,
    OP_ADDWC  = 4'd1,
    OP_SUBW   = 4'd2,
    OP_SUBWC  = 4'd3,
    OP_ADDD   = 4'd4,
    OP_ADDDC  = 4'd5,
    OP_SUBD   = 4'd6,
    OP_SUBDC  = 4'd7,
    OP_AND    = 4'd8,
    OP_OR     = 4'd9,
    OP_XOR    = 4'd10,
    OP_NOR    = 4'd11,
    OP_SLT    = 4'd12,
    OP_SLTU   = 4'd13,
    OP_TRAPEQ = 4'd14,
    OP_NONE   = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_ARITH,
    SRC_LOGIC,
    SRC_LTS,
    SRC_LTU
  } res_src_e;
endpackage

// File: rtl/wide_alu_addsub.sv
module wide_alu_addsub #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  input  logic            word,
  output logic [XLEN-1:0] res
);
  localparam int EXT = XLEN - WLEN;

  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};
    if (word) res = {{EXT{sum[WLEN-1]}}, sum[WLEN-1:0]};
    else      res = sum;
  end
endmodule

// File: rtl/wide_alu_logic.sv
module wide_alu_logic
  import wide_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic_sel_e      sel,
  output logic [XLEN-1:0] res
);
  always_comb begin
    unique case (sel)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = ~(a | b);
    endcase
  end
endmodule

// File: rtl/wide_alu_cmp.sv
module wide_alu_cmp #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            lt_s,
  output logic            lt_u,
  output logic            eq
);
  logic [XLEN:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    lt_u = diff[XLEN];
    // signs differ: a is smaller when a is negative
    if (a[XLEN-1] != b[XLEN-1]) lt_s = a[XLEN-1];
    else                        lt_s = diff[XLEN];
    eq   = (a == b);
  end
endmodule

// File: rtl/wide_alu.sv
module wide_alu
  import wide_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int OPW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_trap
);
  localparam int EXT = XLEN - WLEN;

  alu_op_e         op;
  logic            as_sub, as_word, trap_op;
  logic_sel_e      lg_sel;
  res_src_e        src;
  logic [XLEN-1:0] arith_res, logic_res, next_res;
  logic            lt_s, lt_u, eq;

  always_comb begin
    op      = alu_op_e'(in_op);
    as_sub  = 1'b0;
    as_word = 1'b0;
    trap_op = 1'b0;
    lg_sel  = LG_AND;
    src     = SRC_ZERO;
    unique case (op)
      OP_ADDW, OP_ADDWC: begin src = SRC_ARITH; as_word = 1'b1; end
      OP_SUBW, OP_SUBWC: begin src = SRC_ARITH; as_word = 1'b1; as_sub = 1'b1; end
      OP_ADDD, OP_ADDDC: src = SRC_ARITH;
      OP_SUBD, OP_SUBDC: begin src = SRC_ARITH; as_sub = 1'b1; end
      OP_AND:  begin src = SRC_LOGIC; lg_sel = LG_AND; end
      OP_OR:   begin src = SRC_LOGIC; lg_sel = LG_OR;  end
      OP_XOR:  begin src = SRC_LOGIC; lg_sel = LG_XOR; end
      OP_NOR:  begin src = SRC_LOGIC; lg_sel = LG_NOR; end
      OP_SLT:  src = SRC_LTS;
      OP_SLTU: src = SRC_LTU;
      OP_TRAPEQ: trap_op = 1'b1;
      default: src = SRC_ZERO;
    endcase
  end

  wide_alu_addsub #(.XLEN(XLEN), .WLEN(WLEN)) u_addsub (
    .a(in_a), .b(in_b), .sub(as_sub), .word(as_word), .res(arith_res)
  );

  wide_alu_logic #(.XLEN(XLEN)) u_logic (
    .a(in_a), .b(in_b), .sel(lg_sel), .res(logic_res)
  );

  wide_alu_cmp #(.XLEN(XLEN)) u_cmp (
    .a(in_a), .b(in_b), .lt_s(lt_s), .lt_u(lt_u), .eq(eq)
  );

  always_comb begin
    unique case (src)
      SRC_ARITH: next_res = arith_res;
      SRC_LOGIC: next_res = logic_res;
      SRC_LTS:   next_res = {{(XLEN-1){1'b0}}, lt_s};
      SRC_LTU:   next_res = {{(XLEN-1){1'b0}}, lt_u};
      default:   next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_trap   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_result <= next_res;
      out_trap   <= trap_op & eq;
    end
  end

  // R1
  word_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op) < 4'd4) |-> (out_result[XLEN-1:WLEN] == {EXT{out_result[WLEN-1]}}));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_op) < 4'd8) |-> !out_trap);

  // R5 R6
  setlt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_op) == 4'd12 || $past(in_op) == 4'd13) |-> (out_result[XLEN-1:1] == '0));

  // R7
  trap_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_op) == 4'd14) |-> (out_result == '0));

  // R7
  trap_only_eq_chk: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> ($past(in_op) == 4'd14 && $past(in_a) == $past(in_b)));

  // R8
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_op) == 4'd15) |-> (out_result == '0 && !out_trap));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));
endmodule

// File: tb/wide_alu_bench.sv
module wide_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [63:0] in_a, in_b;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_trap;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] res;
    logic        trap;
    logic [3:0]  op;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  wide_alu u_wide_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_result(out_result), .out_trap(out_trap)
  );

  function automatic string req_of(logic [3:0] op);
    if (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd7) return "R2";
    if (op < 4'd4)   return "R1";
    if (op < 4'd8)   return "R3";
    if (op < 4'd12)  return "R4";
    if (op == 4'd12) return "R5";
    if (op == 4'd13) return "R6";
    if (op == 4'd14) return "R7";
    return "R8";
  endfunction

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    exp_t e;
    e.op = op; e.trap = 1'b0; e.res = 64'd0;
    case (op)
      4'd0, 4'd1: e.res = sx32(a[31:0] + b[31:0]);
      4'd2, 4'd3: e.res = sx32(a[31:0] - b[31:0]);
      4'd4, 4'd5: e.res = a + b;
      4'd6, 4'd7: e.res = a - b;
      4'd8:  e.res = a & b;
      4'd9:  e.res = a | b;
      4'd10: e.res = a ^ b;
      4'd11: e.res = ~(a | b);
      4'd12: e.res = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      4'd13: e.res = (a < b) ? 64'd1 : 64'd0;
      4'd14: e.trap = (a == b);
      default: ;
    endcase
    return e;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    sb.push_back(model(op, a, b));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R9", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(req_of(e.op), out_result, e.res);
        check(req_of(e.op), {63'd0, out_trap}, {63'd0, e.trap});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] edges [8];
    edges[0] = 64'h0000_0000_0000_0000;
    edges[1] = 64'h0000_0000_7FFF_FFFF;
    edges[2] = 64'h0000_0000_8000_0000;
    edges[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    edges[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    edges[5] = 64'h8000_0000_0000_0000;
    edges[6] = 64'h1234_5678_FFFF_FFFF;
    edges[7] = 64'h0000_0000_0000_0001;

    rst = 1'b1; in_valid = 1'b0; in_op = 4'd0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R10: outputs cleared under reset
    check("R10", {62'd0, out_valid, out_trap}, 64'd0);
    check("R10", out_result, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // boundary sweep of every code over sign edges (R1..R8)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          drive(4'(op), edges[i], edges[j]);
    idle();

    // pseudo-random operands, with gaps in valid (R9)
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = (k % 5 == 0) ? a : {$urandom(), $urandom()};
      drive(4'(k % 16), a, b);
      if (k % 7 == 0) begin
        idle();
        // R9: nothing issued last cycle, out_valid must be low
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0);
      end
    end
    idle();
    repeat (3) @(negedge clk);
    // R9: every issued operation produced exactly one result
    check("R9", 64'(sb.size()), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule